// File: doc/BRIEF.md
# Vector Load Unit with Destination Rotation and Staging Register

This block executes the two memory-load operations of a small SIMD coprocessor. An accepted command carries an opcode, the current value of an address register, a second register value used as the post-increment amount, a destination vector index, the condition register and a selector that picks one condition bit. The unit drives one byte address per lane on a combinational memory read port. A row load addresses consecutive bytes. A column load steps the address by a configured stride from lane to lane. The unit collects the returned bytes into a 128-bit vector.

One cycle after acceptance, the unit always writes the collected vector into a hidden staging register, and it always writes the incremented address back to the address register. It also writes the vector into the architectural vector file, but only when the selected condition bit is set. For that write, the two low bits of the destination index are rotated by condition bits 5:4. A dedicated output presents the staging register to a downstream arithmetic unit, and a second copy of it serves as a debug readout.

The command interface is valid/ready. `cmd_ready` is low while reset is asserted and in the first cycle after reset is released, and high from then on. A command is taken on every rising edge where `cmd_valid` and `cmd_ready` are both high, so one command per cycle is sustained. The write ports cannot apply back-pressure. Their strobes are single-cycle pulses that the register files must accept.

Top module: `vload_unit`

## Requirements
- R1: Opcode 0xC8 (row load): lane i reads the memory address (A + i) mod 2^AW, where A is `cmd_addr`. The byte returned for lane i lands in bits [8i+7:8i] of the loaded vector.
- R2: Opcode 0xC9 (column load): lane i reads the memory address (A + i*`cfg_stride`) mod 2^AW. The lane byte order is the same as in R1.
- R3: In the cycle after a load is accepted, `areg_we` is 1, `areg_idx` equals the accepted `cmd_aidx`, and `areg_wdata` equals (A + `cmd_incr`) mod 2^AW. The access itself uses the old value A.
- R4: In the cycle after a load is accepted, `vreg_we` is 1 exactly when bit `cmd_csel` of `cmd_cond` was 1. When that bit is 0, no vector-file write occurs. When the write occurs, `vreg_wdata` is the loaded vector.
- R5: The vector write index is {dst[4:2], (dst[1:0] + cond[5:4]) mod 4}. The upper three bits pass through unchanged.
- R6: Every accepted load replaces the staging register, seen on `hid_rd_data` and `dbg_hid`, with the loaded vector one cycle later. This happens whether or not R4 enables the vector-file write.
- R7: The staging register is zero after reset. It changes only on an accepted load. An accepted command with any other opcode causes no write of any kind.
- R8: `cmd_ready` is 0 during reset and 1 from the second cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 8 | Opcode (0xC8 row, 0xC9 column) |
| cmd_dst | input | 5 | Destination vector index before rotation |
| cmd_addr | input | AW | Current address register value |
| cmd_aidx | input | 4 | Address register index for write-back |
| cmd_incr | input | AW | Post-increment amount (second register) |
| cmd_cond | input | CW | Condition register |
| cmd_csel | input | log2(CW) | Selects the enabling condition bit |
| cfg_stride | input | AW | Column load stride |
| mem_addr | output | LANES*AW | Per-lane byte addresses |
| mem_rdata | input | LANES*8 | Per-lane bytes, combinational return |
| vreg_we | output | 1 | Vector file write strobe |
| vreg_idx | output | 5 | Rotated vector write index |
| vreg_wdata | output | LANES*8 | Vector write data |
| areg_we | output | 1 | Address register write strobe |
| areg_idx | output | 4 | Address register index |
| areg_wdata | output | AW | Incremented address |
| hid_rd_data | output | LANES*8 | Staging register for the consumer |
| dbg_hid | output | LANES*8 | Staging register debug readout |

## Verification
The assertions check the following on every cycle: lane 1 addressing for both opcodes, the address write-back value, the gating of the vector write by the selected condition bit, the pass-through of the upper index bits, loading of the staging register, its stability when no load is accepted, and the absence of writes for non-load opcodes. The bench scenarios show the behaviour that needs the full lane set or a reference memory. That covers the full 16-lane gather in both orders, stride and address wraparound, the modulo-4 rotation of the low index bits, and the staging register holding a value across later commands whose vector write is suppressed.

// File: rtl/vload_pkg.sv
package vload_pkg;
  localparam logic [7:0] OP_ROW_LD = 8'hC8;
  localparam logic [7:0] OP_COL_LD = 8'hC9;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned VIDX_W   = 5;
  localparam int unsigned AIDX_W   = 4;
  localparam int unsigned ROT_LSB  = 4;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_ROW  = 2'd1,
    LD_COL  = 2'd2
  } ld_kind_e;

  function automatic ld_kind_e decode_op(input logic [7:0] op);
    ld_kind_e k;
    case (op)
      OP_ROW_LD: k = LD_ROW;
      OP_COL_LD: k = LD_COL;
      default:   k = LD_NONE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/vload_lane_addr.sv
module vload_lane_addr #(
  parameter int unsigned LANES = 16,
  parameter int unsigned AW    = 16
) (
  input  logic [AW-1:0]       base,
  input  logic [AW-1:0]       stride,
  input  logic                col_mode,
  output logic [LANES*AW-1:0] lane_addr
);
  logic [AW-1:0] step;
  assign step = col_mode ? stride : AW'(1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [AW-1:0] offs;
    assign offs = AW'(g) * step;
    assign lane_addr[g*AW +: AW] = base + offs;
  end
endmodule

// File: rtl/vload_dst_map.sv
module vload_dst_map #(
  parameter int unsigned IW  = 5,
  parameter int unsigned RW  = 2
) (
  input  logic [IW-1:0] dst,
  input  logic [RW-1:0] rot,
  output logic [IW-1:0] idx
);
  logic [RW-1:0] low_sum;
  assign low_sum = dst[RW-1:0] + rot;
  assign idx     = {dst[IW-1:RW], low_sum};
endmodule

// File: rtl/vload_stage.sv
module vload_stage #(
  parameter int unsigned DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/vload_unit.sv
module vload_unit
  import vload_pkg::*;
#(
  parameter int unsigned LANES = 16,
  parameter int unsigned AW    = 16,
  parameter int unsigned CW    = 16,
  localparam int unsigned DW   = LANES * BYTE_W,
  localparam int unsigned SW   = $clog2(CW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [7:0]          cmd_op,
  input  logic [VIDX_W-1:0]   cmd_dst,
  input  logic [AW-1:0]       cmd_addr,
  input  logic [AIDX_W-1:0]   cmd_aidx,
  input  logic [AW-1:0]       cmd_incr,
  input  logic [CW-1:0]       cmd_cond,
  input  logic [SW-1:0]       cmd_csel,
  input  logic [AW-1:0]       cfg_stride,
  output logic [LANES*AW-1:0] mem_addr,
  input  logic [DW-1:0]       mem_rdata,
  output logic                vreg_we,
  output logic [VIDX_W-1:0]   vreg_idx,
  output logic [DW-1:0]       vreg_wdata,
  output logic                areg_we,
  output logic [AIDX_W-1:0]   areg_idx,
  output logic [AW-1:0]       areg_wdata,
  output logic [DW-1:0]       hid_rd_data,
  output logic [DW-1:0]       dbg_hid
);
  ld_kind_e          kind;
  logic              fire;
  logic              is_load;
  logic              cond_ok;
  logic              vwr;
  logic [VIDX_W-1:0] idx_map;
  logic [AW-1:0]     next_addr;
  logic              ready_q;

  assign kind    = decode_op(cmd_op);
  assign is_load = (kind != LD_NONE);
  assign fire    = cmd_valid && ready_q;
  assign cond_ok = cmd_cond[cmd_csel];
  assign vwr     = fire && is_load && cond_ok;
  assign next_addr = cmd_addr + cmd_incr;
  assign cmd_ready = ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  vload_lane_addr #(.LANES(LANES), .AW(AW)) u_addr (
    .base      (cmd_addr),
    .stride    (cfg_stride),
    .col_mode  (kind == LD_COL),
    .lane_addr (mem_addr)
  );

  vload_dst_map #(.IW(VIDX_W), .RW(2)) u_map (
    .dst (cmd_dst),
    .rot (cmd_cond[ROT_LSB +: 2]),
    .idx (idx_map)
  );

  vload_stage #(.DW(DW)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire && is_load),
    .d     (mem_rdata),
    .q     (hid_rd_data)
  );

  assign dbg_hid = hid_rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vreg_we    <= 1'b0;
      vreg_idx   <= '0;
      vreg_wdata <= '0;
      areg_we    <= 1'b0;
      areg_idx   <= '0;
      areg_wdata <= '0;
    end else begin
      vreg_we <= vwr;
      areg_we <= fire && is_load;
      if (vwr) begin
        vreg_idx   <= idx_map;
        vreg_wdata <= mem_rdata;
      end
      if (fire && is_load) begin
        areg_idx   <= cmd_aidx;
        areg_wdata <= next_addr;
      end
    end
  end
endmodule

// File: rtl/vload_unit_chk.sv
module vload_unit_chk
  import vload_pkg::*;
#(
  parameter int unsigned LANES = 16,
  parameter int unsigned AW    = 16,
  parameter int unsigned CW    = 16,
  localparam int unsigned DW   = LANES * BYTE_W,
  localparam int unsigned SW   = $clog2(CW)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic [7:0]          cmd_op,
  input logic [VIDX_W-1:0]   cmd_dst,
  input logic [AW-1:0]       cmd_addr,
  input logic [AIDX_W-1:0]   cmd_aidx,
  input logic [AW-1:0]       cmd_incr,
  input logic [CW-1:0]       cmd_cond,
  input logic [SW-1:0]       cmd_csel,
  input logic [AW-1:0]       cfg_stride,
  input logic [LANES*AW-1:0] mem_addr,
  input logic [DW-1:0]       mem_rdata,
  input logic                vreg_we,
  input logic [VIDX_W-1:0]   vreg_idx,
  input logic [DW-1:0]       vreg_wdata,
  input logic                areg_we,
  input logic [AIDX_W-1:0]   areg_idx,
  input logic [AW-1:0]       areg_wdata,
  input logic [DW-1:0]       hid_rd_data,
  input logic [DW-1:0]       dbg_hid
);
  logic acc_ld, acc_other;
  logic [AW-1:0] sum_addr;
  assign acc_ld    = cmd_valid && cmd_ready && (cmd_op == OP_ROW_LD || cmd_op == OP_COL_LD);
  assign acc_other = cmd_valid && cmd_ready && !(cmd_op == OP_ROW_LD || cmd_op == OP_COL_LD);
  assign sum_addr  = cmd_addr + cmd_incr;

  AST_ROW_LANE1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ROW_LD) |-> mem_addr[AW +: AW] == AW'(cmd_addr + AW'(1))); // R1
  AST_COL_LANE1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_COL_LD) |-> mem_addr[AW +: AW] == AW'(cmd_addr + cfg_stride)); // R2
  AST_ADDR_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ld |=> (areg_we && areg_wdata == $past(sum_addr) && areg_idx == $past(cmd_aidx))); // R3
  AST_VWRITE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ld |=> (vreg_we == $past(cmd_cond[cmd_csel]))); // R4
  AST_IDX_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ld && cmd_cond[cmd_csel]) |=> (vreg_idx[VIDX_W-1:2] == $past(cmd_dst[VIDX_W-1:2]))); // R5
  AST_STAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ld |=> (hid_rd_data == $past(mem_rdata))); // R6
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ld |=> $stable(hid_rd_data)); // R7
  AST_OTHER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_other |=> (!vreg_we && !areg_we)); // R7
  AST_DBG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_hid == hid_rd_data); // R6
endmodule

bind vload_unit vload_unit_chk #(.LANES(LANES), .AW(AW), .CW(CW)) u_chk (.*);

// File: tb/sim_vload_unit.sv
module sim_vload_unit;
  localparam int LANES = 16;
  localparam int AW    = 16;
  localparam int CW    = 16;
  localparam int DW    = LANES * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [7:0] cmd_op = '0;
  logic [4:0] cmd_dst = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [3:0] cmd_aidx = '0;
  logic [AW-1:0] cmd_incr = '0;
  logic [CW-1:0] cmd_cond = '0;
  logic [3:0] cmd_csel = '0;
  logic [AW-1:0] cfg_stride = '0;
  logic [LANES*AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic vreg_we, areg_we;
  logic [4:0] vreg_idx;
  logic [DW-1:0] vreg_wdata, hid_rd_data, dbg_hid;
  logic [3:0] areg_idx;
  logic [AW-1:0] areg_wdata;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_hid = '0;

  always #2 clk = ~clk;

  vload_unit u0 (.*);

  function automatic logic [7:0] memf(input logic [AW-1:0] a);
    return 8'((a * 37) ^ (a >> 7) ^ 8'h5A);
  endfunction

  always_comb begin
    for (int i = 0; i < LANES; i++)
      mem_rdata[i*8 +: 8] = memf(mem_addr[i*AW +: AW]);
  end

  function automatic logic [DW-1:0] exp_vec(input logic col, input logic [AW-1:0] a,
                                            input logic [AW-1:0] s);
    logic [DW-1:0] v;
    for (int i = 0; i < LANES; i++) begin
      logic [AW-1:0] la;
      la = col ? AW'(a + AW'(i) * s) : AW'(a + AW'(i));
      v[i*8 +: 8] = memf(la);
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] op, input logic [4:0] dst, input logic [AW-1:0] a,
                     input logic [3:0] ai, input logic [AW-1:0] inc, input logic [CW-1:0] c,
                     input logic [3:0] cs, input logic [AW-1:0] st);
    logic ld, en;
    logic [DW-1:0] v;
    logic [4:0] xi;
    cmd_valid = 1'b1; cmd_op = op; cmd_dst = dst; cmd_addr = a; cmd_aidx = ai;
    cmd_incr = inc; cmd_cond = c; cmd_csel = cs; cfg_stride = st;
    ld = (op == 8'hC8) || (op == 8'hC9);
    en = ld && c[cs];
    v  = exp_vec(op == 8'hC9, a, st);
    xi = {dst[4:2], 2'(dst[1:0] + c[5:4])};
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (ld) exp_hid = v;
    check("R4 vreg_we", DW'(vreg_we), DW'(en));
    check("R3 areg_we", DW'(areg_we), DW'(ld));
    if (en) begin
      check(op == 8'hC9 ? "R2 column data" : "R1 row data", vreg_wdata, v);
      check("R5 index", DW'(vreg_idx), DW'(xi));
    end
    if (ld) begin
      check("R3 address", DW'(areg_wdata), DW'(AW'(a + inc)));
      check("R3 aidx", DW'(areg_idx), DW'(ai));
    end
    check("R6 stage", hid_rd_data, exp_hid);
    check("R6 debug", dbg_hid, exp_hid);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8 ready in reset", DW'(cmd_ready), '0);
    check("R7 reset stage", hid_rd_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 ready", DW'(cmd_ready), 1);
    // R1 row load, enabled, rotation 0
    run(8'hC8, 5'd8, 16'h0100, 4'd2, 16'h0010, 16'h0001, 4'd0, 16'h0000);
    // R2 column load, stride wrap
    run(8'hC9, 5'd1, 16'hFF00, 4'd5, 16'h0003, 16'h0001, 4'd0, 16'h1234);
    // R5 rotation wrap: dst=3, rot=3 -> low bits 2
    run(8'hC8, 5'd3, 16'h0040, 4'd1, 16'h0001, 16'h0031, 4'd0, 16'h0);
    run(8'hC8, 5'd31, 16'h0040, 4'd1, 16'h0001, 16'h0021, 4'd0, 16'h0);
    // R3 address wrap, R4 suppressed write, R6 stage still updates
    run(8'hC9, 5'd9, 16'hFFF0, 4'd7, 16'h0020, 16'h0000, 4'd0, 16'h0011);
    // R4 selected bit other than 0
    run(8'hC8, 5'd4, 16'h2222, 4'd3, 16'h0000, 16'h8000, 4'd15, 16'h0);
    // R7 non-load opcode: no writes, stage unchanged
    run(8'hB6, 5'd4, 16'h3333, 4'd3, 16'h0004, 16'hFFFF, 4'd0, 16'h0);
    @(negedge clk);
    check("R7 idle stage hold", hid_rd_data, exp_hid);
    check("R7 idle no write", DW'({vreg_we, areg_we}), '0);
    for (int n = 0; n < 400; n++) begin
      logic [7:0] op;
      logic [2:0] r;
      r  = 3'($urandom);
      op = (r == 3'd0) ? 8'($urandom) : (r[0] ? 8'hC8 : 8'hC9);
      run(op, 5'($urandom), 16'($urandom), 4'($urandom), 16'($urandom),
          16'($urandom), 4'($urandom), 16'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule